// File: doc/BRIEF.md
# Audio Channel Status Capture Engine

This block watches a decoded stream of multichannel audio samples and, when a host asks, captures the channel status bits of one chosen channel into a 184-bit result register. Each input strobe carries a channel index, the channel status bit of that channel's current frame, and a flag that marks the first frame of a 192-frame status block. The engine captures nothing until a request arrives. After a request it waits for a block start on the selected channel. It then takes one bit per frame of that channel and, after the 184th bit, copies the collected word into the result register and raises a sticky completion flag.

The host enables the feature with a mode input, picks the source with a three-bit channel select, and pulses a request input. The host reads the result only after the completion flag is high. The result keeps its previous value for the whole length of a new capture, so a host can still read an old word while the next one is collected.

Top module: `chstat_capture`

## Requirements
- R1: After reset the engine is idle, `captureDone` is low and `statusWord` is all zeros.
- R2: A one-cycle `captureReq` pulse sampled while `modeEn` is high starts a capture. `statusWord` keeps its previous value until that capture completes.
- R3: A `captureReq` sampled while `modeEn` is low starts nothing. `modeEn` going low during a capture abandons it, so `captureDone` stays low and `statusWord` is unchanged.
- R4: Strobe channel index k corresponds to select code k. Code 0 is channel 1 and code 7 is channel 8. Only strobes whose `strobeChan` equals the select code contribute.
- R5: After a request, selected-channel strobes are ignored until one arrives with `strobeBlockStart` high. That strobe's bit becomes `statusWord[0]`.
- R6: The n-th selected-channel frame after the block start, with the block start counted as frame 0, lands in `statusWord[n]`. On the clock edge that samples frame 183, `statusWord` is loaded and `captureDone` rises together. Frames 184 to 191 of the block, and all later frames, have no effect.
- R7: Strobes from any channel other than the selected one never change `statusWord` or the collection position.
- R8: If `chanSel` changes during a capture, the capture restarts and waits for a block start on the newly selected channel.
- R9: A block-start strobe on the selected channel in the middle of collection realigns the capture, so that strobe's bit becomes bit 0 again.
- R10: `captureDone` stays high until the next accepted request. It is low from the edge that accepts the request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobeValid | input | 1 | Audio sample strobe |
| strobeChan | input | 3 | Channel index of the strobe, 0 = channel 1 |
| strobeBit | input | 1 | Channel status bit carried by the strobe |
| strobeBlockStart | input | 1 | Strobe is frame 0 of a status block |
| modeEn | input | 1 | Channel status readout enable |
| chanSel | input | 3 | Source channel select code |
| captureReq | input | 1 | Capture request pulse |
| captureDone | output | 1 | Sticky completion flag |
| statusWord | output | 184 | Captured channel status bits |

## Verification
The bench builds the block with its default values: eight channels and a 184-bit result taken from a 192-frame block. At these sizes a complete capture takes about 1,500 to 3,000 cycles, so several full captures fit in one run. That covers a late start in mid-block, the ignored tail of frames 184 to 191, a select change, a realigning block start and aborts on mode loss. A behavioural model tracks every cycle, and each capture is also checked against a word built from the bit pattern that was sent.

// File: rtl/chstat_pkg.sv
package chstat_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE    = 2'd0,
    CAP_WAIT    = 2'd1,
    CAP_COLLECT = 2'd2
  } capState_t;

  // One-hot action strobes from control to datapath
  typedef struct packed {
    logic startBlock;
    logic writeBit;
    logic commit;
  } capCtl_t;

endpackage

// File: rtl/chstat_ctrl.sv
module chstat_ctrl
  import chstat_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobeValid,
  input  logic [SEL_W-1:0] strobeChan,
  input  logic             strobeBlockStart,
  input  logic             modeEn,
  input  logic [SEL_W-1:0] chanSel,
  input  logic             captureReq,
  input  logic             lastBit,
  output capCtl_t          ctl,
  output logic             captureDone
);

  capState_t        state;
  logic [SEL_W-1:0] selHeld;
  logic             hit, reqOk, busy, abortMode, selMoved;

  assign hit       = strobeValid && (strobeChan == selHeld);
  assign reqOk     = captureReq && modeEn;
  assign busy      = (state != CAP_IDLE);
  assign abortMode = busy && !modeEn;
  assign selMoved  = busy && (chanSel != selHeld);

  always_comb begin
    ctl = '0;
    if (!reqOk && !abortMode && !selMoved && busy && hit) begin
      if (strobeBlockStart) begin
        ctl.startBlock = 1'b1;
      end else if (state == CAP_COLLECT) begin
        if (lastBit) ctl.commit = 1'b1;
        else         ctl.writeBit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= CAP_IDLE;
      selHeld     <= '0;
      captureDone <= 1'b0;
    end else if (reqOk) begin
      state       <= CAP_WAIT;
      selHeld     <= chanSel;
      captureDone <= 1'b0;
    end else if (abortMode) begin
      state <= CAP_IDLE;
    end else if (selMoved) begin
      state   <= CAP_WAIT;
      selHeld <= chanSel;
    end else if (ctl.startBlock) begin
      state <= CAP_COLLECT;
    end else if (ctl.commit) begin
      state       <= CAP_IDLE;
      captureDone <= 1'b1;
    end
  end

  // R10: an accepted request clears the completion flag on the next cycle
  assert_req_clears_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reqOk |=> !captureDone);

  // R3: a request with the mode low leaves an idle engine idle
  assert_mode_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && captureReq && !modeEn) |=> (state == CAP_IDLE));

  // R6: completion rises only after a commit of the last bit
  assert_done_after_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(captureDone) |-> $past(ctl.commit));

  // R8: a select change during a capture goes back to waiting
  assert_sel_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (selMoved && !reqOk && modeEn) |=> (state == CAP_WAIT));

  // R7: control issues at most one datapath action per cycle
  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl));

endmodule

// File: rtl/chstat_datapath.sv
module chstat_datapath
  import chstat_pkg::*;
#(
  parameter int STATUS_BITS = 184,
  localparam int CNT_W = $clog2(STATUS_BITS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  capCtl_t                ctl,
  input  logic                   bitIn,
  output logic                   lastBit,
  output logic [STATUS_BITS-1:0] statusWord
);

  logic [CNT_W-1:0]       bitCount;
  logic [STATUS_BITS-1:0] staging;
  logic [STATUS_BITS-1:0] commitVec;

  assign lastBit = (bitCount == CNT_W'(STATUS_BITS - 1));

  always_comb begin
    commitVec = staging;
    commitVec[STATUS_BITS-1] = bitIn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitCount   <= '0;
      staging    <= '0;
      statusWord <= '0;
    end else begin
      if (ctl.startBlock) begin
        staging[0] <= bitIn;
        bitCount   <= CNT_W'(1);
      end else if (ctl.writeBit) begin
        staging[bitCount] <= bitIn;
        bitCount          <= bitCount + CNT_W'(1);
      end else if (ctl.commit) begin
        statusWord <= commitVec;
        bitCount   <= '0;
      end
    end
  end

  // R6: the write position never runs past the last result bit
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bitCount < CNT_W'(STATUS_BITS));

  // R2: the result only moves on a commit
  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.commit |=> $stable(statusWord));

  // R5: realignment always restarts at bit position 1
  assert_realign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.startBlock |=> (bitCount == CNT_W'(1)));

endmodule

// File: rtl/chstat_capture.sv
module chstat_capture
  import chstat_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int STATUS_BITS = 184,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobeValid,
  input  logic [SEL_W-1:0]       strobeChan,
  input  logic                   strobeBit,
  input  logic                   strobeBlockStart,
  input  logic                   modeEn,
  input  logic [SEL_W-1:0]       chanSel,
  input  logic                   captureReq,
  output logic                   captureDone,
  output logic [STATUS_BITS-1:0] statusWord
);

  capCtl_t ctl;
  logic    lastBit;

  chstat_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .strobeValid      (strobeValid),
    .strobeChan       (strobeChan),
    .strobeBlockStart (strobeBlockStart),
    .modeEn           (modeEn),
    .chanSel          (chanSel),
    .captureReq       (captureReq),
    .lastBit          (lastBit),
    .ctl              (ctl),
    .captureDone      (captureDone)
  );

  chstat_datapath #(.STATUS_BITS(STATUS_BITS)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .bitIn      (strobeBit),
    .lastBit    (lastBit),
    .statusWord (statusWord)
  );

  // R1: out of reset the flag is low and the result is clear
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!captureDone && (statusWord == '0)));

endmodule

// File: tb/chstat_capture_tb_top.sv
module chstat_capture_tb_top;

  localparam int NB  = 184;
  localparam int BLK = 192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobeValid = 1'b0;
  logic [2:0]    strobeChan = '0;
  logic          strobeBit = 1'b0;
  logic          strobeBlockStart = 1'b0;
  logic          modeEn = 1'b0;
  logic [2:0]    chanSel = '0;
  logic          captureReq = 1'b0;
  logic          captureDone;
  logic [NB-1:0] statusWord;

  always #2 clk = ~clk;

  chstat_capture dut_i (
    .clk(clk), .rst_n(rst_n), .strobeValid(strobeValid), .strobeChan(strobeChan),
    .strobeBit(strobeBit), .strobeBlockStart(strobeBlockStart), .modeEn(modeEn),
    .chanSel(chanSel), .captureReq(captureReq), .captureDone(captureDone),
    .statusWord(statusWord)
  );

  int checks = 0;
  int fails  = 0;
  int salt   = 0;
  bit finished = 0;

  task automatic check(string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic pat(int pos, int ch);
    int v;
    v = (pos * 5 + ch * 3 + salt) ^ (pos >> 2) ^ (pos >> 5);
    return v[0];
  endfunction

  function automatic logic [NB-1:0] expVec(int ch);
    logic [NB-1:0] v;
    for (int n = 0; n < NB; n++) v[n] = pat(n, ch);
    return v;
  endfunction

  // Behavioural reference model, stepped on each rising edge
  int            mState = 0;
  int            mCount = 0;
  int            mSel = 0;
  logic [NB-1:0] mStage = '0;
  logic [NB-1:0] mResult = '0;
  logic          mDone = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mState = 0; mCount = 0; mSel = 0; mStage = '0; mResult = '0; mDone = 1'b0;
    end else if (captureReq && modeEn) begin
      mState = 1; mSel = int'(chanSel); mDone = 1'b0;
    end else if (mState != 0 && !modeEn) begin
      mState = 0;
    end else if (mState != 0 && int'(chanSel) != mSel) begin
      mSel = int'(chanSel); mState = 1;
    end else if (mState != 0 && strobeValid && int'(strobeChan) == mSel) begin
      if (strobeBlockStart) begin
        mStage[0] = strobeBit; mCount = 1; mState = 2;
      end else if (mState == 2) begin
        mStage[mCount] = strobeBit;
        mCount++;
        if (mCount == NB) begin
          mResult = mStage; mDone = 1'b1; mState = 0;
        end
      end
    end
  end

  // R6 R7: compare against the model every cycle, between edges
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R6 model flag", NB'(captureDone), NB'(mDone));
      check("R7 model word", statusWord, mResult);
    end
  end

  task automatic sendFrame(int pos);
    for (int ch = 0; ch < 8; ch++) begin
      @(negedge clk); #1;
      strobeValid = 1'b1;
      strobeChan = 3'(ch);
      strobeBit = pat(pos, ch);
      strobeBlockStart = (pos == 0);
    end
    @(negedge clk); #1;
    strobeValid = 1'b0;
    strobeBlockStart = 1'b0;
  endtask

  task automatic sendFrames(int start, int n);
    for (int i = 0; i < n; i++) sendFrame((start + i) % BLK);
  endtask

  task automatic request(int sel);
    @(negedge clk); #1;
    chanSel = 3'(sel);
    captureReq = 1'b1;
    @(negedge clk); #1;
    captureReq = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  logic [NB-1:0] held;

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    settle();
    check("R1 reset flag", NB'(captureDone), NB'(0));
    check("R1 reset word", statusWord, '0);

    // R5 R4 R7: mid-block start, channel 3 (code 2)
    salt = 1;
    modeEn = 1'b1;
    request(2);
    sendFrames(100, 92 + 150);
    settle();
    check("R5 not done before frame 183", NB'(captureDone), NB'(0));
    sendFrames(150, 34);
    settle();
    check("R6 done after frame 183", NB'(captureDone), NB'(1));
    check("R4 R7 word is channel 3", statusWord, expVec(2));
    held = statusWord;

    // R6 R10: tail frames and a later block do not disturb a finished capture
    sendFrames(184, 8 + 40);
    settle();
    check("R6 tail ignored", statusWord, held);
    check("R10 flag sticky", NB'(captureDone), NB'(1));

    // R2 R10 R4: new request on channel 8 (code 7)
    salt = 2;
    request(7);
    settle();
    check("R10 flag cleared by request", NB'(captureDone), NB'(0));
    sendFrames(0, 100);
    settle();
    check("R2 old word held during capture", statusWord, held);
    sendFrames(100, 84);
    settle();
    check("R4 word is channel 8", statusWord, expVec(7));
    check("R2 done", NB'(captureDone), NB'(1));
    held = statusWord;

    // R3: request with mode low is ignored
    salt = 3;
    modeEn = 1'b0;
    request(1);
    sendFrames(0, BLK);
    settle();
    check("R3 gated request flag", NB'(captureDone), NB'(1));
    check("R3 gated request word", statusWord, held);

    // R3: mode loss aborts a running capture
    modeEn = 1'b1;
    request(1);
    sendFrames(0, 60);
    modeEn = 1'b0;
    sendFrames(60, 132 + 184);
    settle();
    check("R3 abort flag", NB'(captureDone), NB'(0));
    check("R3 abort word", statusWord, held);
    modeEn = 1'b1;

    // R8: select change mid-capture restarts on the new channel
    salt = 4;
    request(0);
    sendFrames(0, 60);
    @(negedge clk); #1 chanSel = 3'd5;
    sendFrames(60, 132);
    settle();
    check("R8 not done after select change", NB'(captureDone), NB'(0));
    sendFrames(0, 184);
    settle();
    check("R8 word is channel 6", statusWord, expVec(5));

    // R9: a fresh block start realigns collection
    salt = 5;
    request(4);
    sendFrames(0, 50);
    salt = 6;
    sendFrames(0, 184);
    settle();
    check("R9 realigned done", NB'(captureDone), NB'(1));
    check("R9 realigned word", statusWord, expVec(4));

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule